// File: doc/BRIEF.md
# Paired-Bit Approximate Signed Adder

This block adds two signed two's-complement operands of `WIDTH` bits and returns a sign-extended sum of `WIDTH+1` bits that can never overflow. The `APX` least significant bits are computed approximately. They are cut into two-bit groups, and each group is added on its own with no carry arriving from below. Every group except the topmost one clamps its result at binary 11 when its true sum needs a third bit. The topmost approximate group keeps its full three-bit sum, and its carry enters an exact ripple-carry section that adds the upper `WIDTH-APX` bits after sign extension.

Because of this arrangement the result is never larger than the exact sum. The result is exact whenever no group produces a carry into the group above it. The error magnitude is bounded by the lowest `APX-2` bits. With `APX = 2` the adder is exact.

Operands are captured in an input register and the sum is held in an output register, so a result appears two clocks after its operands. A new operand pair can be accepted every clock. A synchronous active-high reset clears both register stages.

Top module: `apx_adder`

## Requirements
- R1: `sum` is the `WIDTH+1`-bit two's-complement result. Its upper `WIDTH-APX+1` bits are the exact sum of the sign-extended operand bits `WIDTH-1..APX` plus the carry from the top approximate group, so the most negative and most positive operands do not overflow.
- R2: For every two-bit group at bit positions `2g+1..2g` with `2g+2 < APX`, the group's sum bits equal the sum of the two operand slices when that sum is 3 or less, and equal binary 11 when the sum is 4 to 6.
- R3: The group at bit positions `APX-1..APX-2` outputs the low two bits of the exact sum of its slices, and its third bit is the carry into the exact upper section.
- R4: No group receives a carry from the group below it. Whenever no group's slice sum exceeds 3, the result equals the exact sum.
- R5: The approximate result minus the exact sum lies in the range [-(2^(APX-2)-1), 0].
- R6: With `APX = 2` the result equals the exact sum for all operand pairs.
- R7: Elaboration stops with an error unless `APX` is even and 2 <= `APX` < `WIDTH`.
- R8: A result appears on `sum` exactly two rising clock edges after its operands are presented. Back-to-back operand pairs yield back-to-back results.
- R9: At a clock edge with `rst` high, both the input and output registers clear, so `sum` reads 0 after that edge. It stays 0 for the edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opA | input | WIDTH | First signed operand |
| opB | input | WIDTH | Second signed operand |
| sum | output | WIDTH+1 | Registered approximate signed sum |

## Verification
An operand pair driven between two rising edges is captured at the first edge and shows up on `sum` after the second. The bench therefore drives on falling edges and compares the output two falling edges later, pairing each result with the operands it keeps in a two-deep history. The latency check also samples after only one edge, where the previous result must still be present. The reset checks sample one falling edge after the reset edge, and again one edge after release, where the cleared input stage must still yield 0.

// File: rtl/apx_pkg.sv
package apx_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;   // clear both register stages
    logic load;  // capture operands and result
  } apx_strobe_t;

endpackage

// File: rtl/apx_pair_sat.sv
// Two-bit group without carry-in whose result clamps at 3 (R2, R4).
module apx_pair_sat (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [1:0] s
);
  logic lowSum, lowCarry, hiSum, grpCarry;

  always_comb begin
    lowSum   = a[0] ^ b[0];
    lowCarry = a[0] & b[0];
    hiSum    = a[1] ^ b[1] ^ lowCarry;
    grpCarry = (a[1] & b[1]) | (lowCarry & (a[1] ^ b[1]));
    s        = {hiSum | grpCarry, lowSum | grpCarry};
  end
endmodule

// File: rtl/apx_pair_top.sv
// Top approximate group: exact three-bit sum, carry goes upward (R3).
module apx_pair_top (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [1:0] s,
  output logic       cout
);
  logic lowCarry;

  always_comb begin
    lowCarry = a[0] & b[0];
    s[0]     = a[0] ^ b[0];
    s[1]     = a[1] ^ b[1] ^ lowCarry;
    cout     = (a[1] & b[1]) | (lowCarry & (a[1] ^ b[1]));
  end
endmodule

// File: rtl/apx_ripple.sv
// Exact ripple-carry section over already sign-extended slices (R1).
module apx_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s
);
  logic [W-1:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_next
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/apx_ctrl.sv
// Turns the reset input into datapath strobes.
module apx_ctrl
  import apx_pkg::*;
(
  input  logic        rst,
  output apx_strobe_t stb
);
  always_comb begin
    stb.clr  = rst;
    stb.load = ~rst;
  end
endmodule

// File: rtl/apx_datapath.sv
module apx_datapath
  import apx_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int APX   = 6
) (
  input  logic             clk,
  input  apx_strobe_t      stb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH:0]   sum
);
  localparam int NLOW   = APX / 2 - 1;
  localparam int HIW    = WIDTH - APX + 1;
  localparam int MAXERR = (1 << (APX - 2)) - 1;

  logic [WIDTH-1:0] aQ, bQ;
  logic [WIDTH:0]   approxComb;
  logic             topCarry;

  // input stage
  always_ff @(posedge clk) begin
    if (stb.clr) begin
      aQ <= '0;
      bQ <= '0;
    end else if (stb.load) begin
      aQ <= opA;
      bQ <= opB;
    end
  end

  // lower saturating groups
  for (genvar g = 0; g < NLOW; g++) begin : g_low
    apx_pair_sat u_sat (
      .a(aQ[2*g+1:2*g]),
      .b(bQ[2*g+1:2*g]),
      .s(approxComb[2*g+1:2*g])
    );

    a_r2_saturate: assert property (@(posedge clk) disable iff (stb.clr)
      (({1'b0, aQ[2*g+1:2*g]} + {1'b0, bQ[2*g+1:2*g]}) > 3'd3)
        ? (approxComb[2*g+1:2*g] == 2'b11)
        : (approxComb[2*g+1:2*g] == aQ[2*g+1:2*g] + bQ[2*g+1:2*g]));
  end

  apx_pair_top u_top (
    .a   (aQ[APX-1:APX-2]),
    .b   (bQ[APX-1:APX-2]),
    .s   (approxComb[APX-1:APX-2]),
    .cout(topCarry)
  );

  apx_ripple #(.W(HIW)) u_hi (
    .a  ({aQ[WIDTH-1], aQ[WIDTH-1:APX]}),
    .b  ({bQ[WIDTH-1], bQ[WIDTH-1:APX]}),
    .cin(topCarry),
    .s  (approxComb[WIDTH:APX])
  );

  // output stage
  always_ff @(posedge clk) begin
    if (stb.clr) sum <= '0;
    else if (stb.load) sum <= approxComb;
  end

  // reference values for the checks below
  logic signed [WIDTH:0]   exactRef;
  logic signed [WIDTH+1:0] errDiff;
  assign exactRef = $signed({aQ[WIDTH-1], aQ}) + $signed({bQ[WIDTH-1], bQ});
  assign errDiff  = $signed({exactRef[WIDTH], exactRef})
                  - $signed({approxComb[WIDTH], approxComb});

  a_r3_top_carry: assert property (@(posedge clk) disable iff (stb.clr)
    topCarry == (({1'b0, aQ[APX-1:APX-2]} + {1'b0, bQ[APX-1:APX-2]}) >= 3'd4));

  a_r5_err_bound: assert property (@(posedge clk) disable iff (stb.clr)
    (errDiff >= 0) && (errDiff <= $signed((WIDTH+2)'(MAXERR))));

  a_r9_clear: assert property (@(posedge clk)
    stb.clr |=> (sum == '0) && (aQ == '0) && (bQ == '0));

  if (APX == 2) begin : g_exact
    a_r6_exact: assert property (@(posedge clk) disable iff (stb.clr)
      approxComb == exactRef);
  end
endmodule

// File: rtl/apx_adder.sv
module apx_adder
  import apx_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int APX   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH:0]   sum
);
  // R7: parameter legality
  if ((APX % 2) != 0 || APX < 2 || APX >= WIDTH) begin : g_bad_param
    $error("apx_adder: APX must be even with 2 <= APX < WIDTH");
  end

  apx_strobe_t stb;

  apx_ctrl u_ctrl (
    .rst(rst),
    .stb(stb)
  );

  apx_datapath #(.WIDTH(WIDTH), .APX(APX)) u_dp (
    .clk(clk),
    .stb(stb),
    .opA(opA),
    .opB(opB),
    .sum(sum)
  );
endmodule

// File: tb/sim_apx_adder.sv
`timescale 1ns/1ps
module sim_apx_adder;
  localparam int N0 = 16;
  localparam int K0 = 6;
  localparam int N1 = 8;
  localparam int K1 = 2;
  localparam int NV = 12;

  // directed vectors for N0/K0: operand A, operand B, expected 17-bit sum
  localparam logic [15:0] VA [NV] = '{16'h0000, 16'h0001, 16'h0003, 16'h000F,
                                     16'h0030, 16'h7FFF, 16'h8000, 16'hFFFF,
                                     16'h8000, 16'h0005, 16'h0002, 16'h0040};
  localparam logic [15:0] VB [NV] = '{16'h0000, 16'h0002, 16'h0001, 16'h0001,
                                     16'h0010, 16'h7FFF, 16'h8000, 16'h0001,
                                     16'h7FFF, 16'h000A, 16'h0002, 16'hFFC0};
  localparam logic [16:0] VE [NV] = '{17'h00000, 17'h00003, 17'h00003, 17'h0000F,
                                     17'h00040, 17'h0FFEF, 17'h10000, 17'h1FFFF,
                                     17'h1FFFF, 17'h0000F, 17'h00003, 17'h00000};
  localparam string VT [NV] = '{"R4", "R4", "R2", "R2", "R3", "R1",
                               "R1", "R2", "R1", "R4", "R2", "R1"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N0-1:0] a0 = '0, b0 = '0;
  logic [N1-1:0] a1 = '0, b1 = '0;
  logic [N0:0] sum0;
  logic [N1:0] sum1;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  apx_adder #(.WIDTH(N0), .APX(K0)) u0 (.clk(clk), .rst(rst), .opA(a0), .opB(b0), .sum(sum0));
  apx_adder #(.WIDTH(N1), .APX(K1)) u1 (.clk(clk), .rst(rst), .opA(a1), .opB(b1), .sum(sum1));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model of the per-group rules, on sign-extended values
  function automatic longint refApprox(longint a, longint b, int k);
    longint low = 0;
    longint s;
    for (int g = 0; g < k / 2 - 1; g++) begin
      s = ((a >> (2 * g)) & 3) + ((b >> (2 * g)) & 3);
      if (s > 3) s = 3;
      low = low | (s << (2 * g));
    end
    s = ((a >> (k - 2)) & 3) + ((b >> (k - 2)) & 3);
    low = low | ((s & 3) << (k - 2));
    return (((a >>> k) + (b >>> k) + (s >> 2)) <<< k) + low;
  endfunction

  initial begin
    #1200000;
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    longint pa1 = 0, pb1 = 0, pa2 = 0, pb2 = 0;
    longint qa1 = 0, qb1 = 0, qa2 = 0, qb2 = 0;
    longint got, exp, na, nb;
    logic [15:0] corner [4] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000};

    // R9: reset state
    repeat (3) @(negedge clk);
    check(sum0 == '0, "R9", longint'(sum0), 0);
    check(sum1 == '0, "R9", longint'(sum1), 0);
    rst = 1'b0;

    // directed table (R1..R4 tagged per row)
    for (int i = 0; i < NV; i++) begin
      a0 = VA[i];
      b0 = VB[i];
      @(negedge clk);
      @(negedge clk);
      check(sum0 == VE[i], VT[i], longint'(sum0), longint'(VE[i]));
    end

    // R8: latency of exactly two edges
    a0 = '0; b0 = '0;
    repeat (2) @(negedge clk);
    a0 = 16'h0001; b0 = 16'h0002;
    @(negedge clk);
    check(sum0 == '0, "R8", longint'(sum0), 0);
    @(negedge clk);
    check(sum0 == 17'd3, "R8", longint'(sum0), 3);

    // streaming: random/corner on u0 (R5, R8), exhaustive on u1 (R6)
    for (int i = 0; i < 65538; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        got = longint'($signed(sum0));
        exp = refApprox(pa2, pb2, K0);
        check(got == exp, "R8", got, exp);
        check((pa2 + pb2 - got) >= 0 && (pa2 + pb2 - got) <= (64'sd1 <<< (K0 - 2)) - 1,
              "R5", got, pa2 + pb2);
        got = longint'($signed(sum1));
        check(got == qa2 + qb2, "R6", got, qa2 + qb2);
      end
      if (i % 8 == 0) begin
        a0 = corner[(i / 8) % 4];
        b0 = corner[(i / 32) % 4];
      end else begin
        a0 = N0'($urandom);
        b0 = N0'($urandom);
      end
      a1 = (i < 65536) ? N1'(i) : '0;
      b1 = (i < 65536) ? N1'(i >> 8) : '0;
      na = longint'($signed(a0));
      nb = longint'($signed(b0));
      pa2 = pa1; pb2 = pb1; pa1 = na; pb1 = nb;
      qa2 = qa1; qb2 = qb1;
      qa1 = longint'($signed(a1));
      qb1 = longint'($signed(b1));
    end

    // R9: reset mid-stream clears output, input stage stays cleared after release
    a0 = 16'h0001; b0 = 16'h0002;
    repeat (2) @(negedge clk);
    check(sum0 == 17'd3, "R9", longint'(sum0), 3);
    rst = 1'b1;
    @(negedge clk);
    check(sum0 == '0, "R9", longint'(sum0), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sum0 == '0, "R9", longint'(sum0), 0);
    @(negedge clk);
    check(sum0 == 17'd3, "R9", longint'(sum0), 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule